// File: doc/BRIEF.md
# Initiator Phase Sequencer for a Parallel Peripheral Bus

This block follows one initiator through a complete command on a shared parallel peripheral bus. The sequence is: wait for a free bus, arbitrate by fixed ID priority, select a target, send one identify byte, send a fixed number of command bytes, and then follow whatever information phases the target drives. The target can transfer data, send status, or send messages. The sequencer counts data bytes as they move. It keeps a saved copy of that count when the target asks for a pointer save, and it reloads the copy when the target asks for a pointer restore.

A target may release the bus in the middle of a command by sending a disconnect message. The sequencer then parks in a disconnected state and waits for the target to reselect it. After reselection, the target must send an identify message before the information phases resume.

Each phase the target reports is checked against what the current state allows. A phase or message that is not allowed ends the command with an error pulse and returns the sequencer to bus free. Byte-level handshaking and electrical signalling sit outside this block. Every target action arrives as a phase code plus a one-cycle byte strobe.

Top module: `init_phase_seq`

## Requirements
- R1: After reset, `phase_o` is FREE (0), `arb_req_o`, `done_o`, `err_o` and `lost_o` are 0, and `data_cnt_o` is 0.
- R2: A `start_i` pulse seen in FREE is remembered. The sequencer enters ARB (`phase_o` = 1, `arb_req_o` = 1) on the edge after a cycle in which a request is pending or `start_i` is high and `bus_free_i` is high. It never enters ARB while `bus_free_i` is low.
- R3: In ARB the sequencer wins if no bit of `arb_ids_i` above index OWN_ID is set; a higher index means higher priority, and its own and lower bits are ignored. A win moves to SEL (2). A loss returns to FREE with a one-cycle `lost_o` and keeps the request pending, so arbitration is retried at the next free bus.
- R4: SEL waits for `sel_ack_i` and then moves to IDENT (3). One strobed byte in target phase MSG_OUT (5) moves to CMD (4). After CMD_LEN strobed bytes in target phase COMMAND (3), the sequencer moves to INFO (5).
- R5: In INFO, each strobed byte in DATA_OUT (1) or DATA_IN (2) adds one to `data_cnt_o`. A target phase without `xfer_i` changes nothing. Winning arbitration clears both the count and its saved copy.
- R6: In INFO, a strobed MSG_IN (6) byte carrying message SAVE (1) copies the count into the saved register. A strobed MSG_IN byte carrying DISCONNECT (3) moves to DISC (7).
- R7: In DISC, target phases are ignored and `resel_i` moves to RESEL (8). A strobed MSG_IN byte carrying IDENTIFY (4) then returns to INFO. In INFO, a strobed MSG_IN byte carrying RESTORE (2) reloads `data_cnt_o` from the saved copy.
- R8: In INFO, a strobed STATUS (4) byte moves to STAT (6). In STAT, a strobed MSG_IN byte carrying COMPLETE (0) returns to FREE with a one-cycle `done_o`.
- R9: Any of the following returns the sequencer to FREE with a one-cycle `err_o` and drops any pending request. In IDENT, CMD, INFO, STAT or RESEL, a non-zero target phase outside the set that state accepts. The accepted sets are: IDENT {5}, CMD {3}, INFO {1,2,4,6}, STAT {6}, RESEL {6}. A strobed message other than the ones listed for INFO, STAT and RESEL. At most one of `done_o`, `err_o` and `lost_o` is high in any cycle.
- R10: A `start_i` pulse outside FREE is ignored: after the command ends, the sequencer stays in FREE on a free bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a command |
| bus_free_i | input | 1 | Bus is currently free |
| arb_ids_i | input | NUM_IDS (8) | ID bits asserted by all contenders during arbitration |
| sel_ack_i | input | 1 | Target answered selection |
| resel_i | input | 1 | Target reselects this initiator |
| tphase_i | input | 3 | Phase driven by target: 0 none, 1 data out, 2 data in, 3 command, 4 status, 5 message out, 6 message in |
| xfer_i | input | 1 | One byte moved in the current target phase |
| msg_i | input | 3 | Message code with the byte: 0 complete, 1 save, 2 restore, 3 disconnect, 4 identify |
| phase_o | output | 4 | Sequencer phase: 0 FREE, 1 ARB, 2 SEL, 3 IDENT, 4 CMD, 5 INFO, 6 STAT, 7 DISC, 8 RESEL |
| arb_req_o | output | 1 | Arbitrating for the bus |
| data_cnt_o | output | CNT_W (16) | Current data byte pointer |
| done_o | output | 1 | Command completed (one cycle) |
| err_o | output | 1 | Protocol error, command aborted (one cycle) |
| lost_o | output | 1 | Arbitration lost (one cycle) |

## Verification
Two events can land on the same edge. A lost arbitration happens while the bus is still free, and on the very next cycle the pending request must start a new arbitration without a fresh `start_i`. Separately, a `start_i` pulse can coincide with `bus_free_i`, and it must take the sequencer straight to ARB without first setting a pending flag. The bench provokes both cases by holding `bus_free_i` high across a loss and by raising `start_i` and `bus_free_i` together. A behavioural model compares the phase, flags and pointer on every clock, so it would catch a one-cycle slip or a dropped retry.

// File: rtl/init_phase_pkg.sv
`timescale 1ns/1ps
package init_phase_pkg;

  typedef enum logic [3:0] {
    PH_FREE  = 4'd0,
    PH_ARB   = 4'd1,
    PH_SEL   = 4'd2,
    PH_IDENT = 4'd3,
    PH_CMD   = 4'd4,
    PH_INFO  = 4'd5,
    PH_STAT  = 4'd6,
    PH_DISC  = 4'd7,
    PH_RESEL = 4'd8
  } seq_phase_e;

  // target phase codes
  localparam logic [2:0] TP_NONE   = 3'd0;
  localparam logic [2:0] TP_DOUT   = 3'd1;
  localparam logic [2:0] TP_DIN    = 3'd2;
  localparam logic [2:0] TP_CMD    = 3'd3;
  localparam logic [2:0] TP_STATUS = 3'd4;
  localparam logic [2:0] TP_MOUT   = 3'd5;
  localparam logic [2:0] TP_MIN    = 3'd6;

  // message codes
  localparam logic [2:0] MS_DONE    = 3'd0;
  localparam logic [2:0] MS_SAVE    = 3'd1;
  localparam logic [2:0] MS_RESTORE = 3'd2;
  localparam logic [2:0] MS_DISC    = 3'd3;
  localparam logic [2:0] MS_IDENT   = 3'd4;

  // Returns 1 when the target phase is acceptable in the given sequencer state.
  function automatic logic phase_allowed(seq_phase_e st, logic [2:0] tp);
    logic ok;
    if (tp == TP_NONE) begin
      ok = 1'b1;
    end else begin
      case (st)
        PH_IDENT: ok = (tp == TP_MOUT);
        PH_CMD:   ok = (tp == TP_CMD);
        PH_INFO:  ok = (tp == TP_DOUT) || (tp == TP_DIN) ||
                       (tp == TP_STATUS) || (tp == TP_MIN);
        PH_STAT:  ok = (tp == TP_MIN);
        PH_RESEL: ok = (tp == TP_MIN);
        default:  ok = 1'b1; // bus not owned: target phases are not ours
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/seq_arb_judge.sv
`timescale 1ns/1ps
module seq_arb_judge #(
  parameter int NUM_IDS = 8,
  parameter int OWN_ID  = 5
) (
  input  logic [NUM_IDS-1:0] contenders_i,
  output logic               higher_o
);
  logic [NUM_IDS-1:0] above_mask;

  generate
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_mask
      assign above_mask[g] = (g > OWN_ID);
    end
  endgenerate

  assign higher_o = |(contenders_i & above_mask);
endmodule

// File: rtl/seq_ptr_store.sv
`timescale 1ns/1ps
module seq_ptr_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             save_i,
  input  logic             restore_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] saved_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] saved_q;

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v);
    return v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q   <= '0;
      saved_q <= '0;
    end else begin
      if (restore_i)  cnt_q <= saved_q;
      else if (inc_i) cnt_q <= bump(cnt_q);
      if (save_i)     saved_q <= cnt_q;
    end
  end

  assign cnt_o   = cnt_q;
  assign saved_o = saved_q;
endmodule

// File: rtl/init_phase_seq.sv
`timescale 1ns/1ps
module init_phase_seq
  import init_phase_pkg::*;
#(
  parameter int NUM_IDS = 8,
  parameter int OWN_ID  = 5,
  parameter int CMD_LEN = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               bus_free_i,
  input  logic [NUM_IDS-1:0] arb_ids_i,
  input  logic               sel_ack_i,
  input  logic               resel_i,
  input  logic [2:0]         tphase_i,
  input  logic               xfer_i,
  input  logic [2:0]         msg_i,
  output logic [3:0]         phase_o,
  output logic               arb_req_o,
  output logic [CNT_W-1:0]   data_cnt_o,
  output logic               done_o,
  output logic               err_o,
  output logic               lost_o
);
  localparam int CMD_W = $clog2(CMD_LEN + 1);
  localparam logic [CMD_W-1:0] CMD_LAST = CMD_W'(CMD_LEN - 1);

  seq_phase_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic             done_q, err_q, lost_q;
  logic             done_d, err_d, lost_d;

  // named internal events
  logic             higher_w;
  logic             ev_win, ev_data, ev_save, ev_restore;
  logic             bad_phase, bad_msg, msg_byte;
  logic [CNT_W-1:0] saved_w;

  seq_arb_judge #(.NUM_IDS(NUM_IDS), .OWN_ID(OWN_ID)) u_judge (
    .contenders_i (arb_ids_i),
    .higher_o     (higher_w)
  );

  seq_ptr_store #(.CNT_W(CNT_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (ev_win),
    .inc_i     (ev_data),
    .save_i    (ev_save),
    .restore_i (ev_restore),
    .cnt_o     (data_cnt_o),
    .saved_o   (saved_w)
  );

  assign bad_phase = !phase_allowed(st_q, tphase_i);
  assign msg_byte  = xfer_i && (tphase_i == TP_MIN);

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    cmd_d      = cmd_q;
    done_d     = 1'b0;
    lost_d     = 1'b0;
    bad_msg    = 1'b0;
    ev_win     = 1'b0;
    ev_data    = 1'b0;
    ev_save    = 1'b0;
    ev_restore = 1'b0;
    if (!bad_phase) begin
      case (st_q)
        PH_FREE: begin
          pend_d = pend_q | start_i;
          if ((pend_q || start_i) && bus_free_i) st_d = PH_ARB;
        end
        PH_ARB: begin
          if (higher_w) begin
            st_d   = PH_FREE;
            lost_d = 1'b1;
          end else begin
            st_d   = PH_SEL;
            pend_d = 1'b0;
            cmd_d  = '0;
            ev_win = 1'b1;
          end
        end
        PH_SEL: if (sel_ack_i) st_d = PH_IDENT;
        PH_IDENT: if (xfer_i && tphase_i == TP_MOUT) st_d = PH_CMD;
        PH_CMD: begin
          if (xfer_i && tphase_i == TP_CMD) begin
            cmd_d = cmd_q + 1'b1;
            if (cmd_q == CMD_LAST) st_d = PH_INFO;
          end
        end
        PH_INFO: begin
          if (xfer_i) begin
            case (tphase_i)
              TP_DOUT, TP_DIN: ev_data = 1'b1;
              TP_STATUS:       st_d    = PH_STAT;
              TP_MIN: begin
                case (msg_i)
                  MS_SAVE:    ev_save    = 1'b1;
                  MS_RESTORE: ev_restore = 1'b1;
                  MS_DISC:    st_d       = PH_DISC;
                  default:    bad_msg    = 1'b1;
                endcase
              end
              default: ;
            endcase
          end
        end
        PH_STAT: begin
          if (msg_byte) begin
            if (msg_i == MS_DONE) begin
              st_d   = PH_FREE;
              done_d = 1'b1;
            end else begin
              bad_msg = 1'b1;
            end
          end
        end
        PH_DISC: if (resel_i) st_d = PH_RESEL;
        PH_RESEL: begin
          if (msg_byte) begin
            if (msg_i == MS_IDENT) st_d = PH_INFO;
            else                   bad_msg = 1'b1;
          end
        end
        default: st_d = PH_FREE;
      endcase
    end
    err_d = bad_phase || bad_msg;
    if (err_d) begin
      st_d   = PH_FREE;
      pend_d = 1'b0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PH_FREE;
      pend_q <= 1'b0;
      cmd_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cmd_q  <= cmd_d;
      done_q <= done_d;
      err_q  <= err_d;
      lost_q <= lost_d;
    end
  end

  assign phase_o   = st_q;
  assign arb_req_o = (st_q == PH_ARB);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign lost_o    = lost_q;
endmodule

// File: rtl/init_phase_seq_chk.sv
`timescale 1ns/1ps
module init_phase_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_free_i,
  input logic [3:0]       phase_o,
  input logic             done_o,
  input logic             err_o,
  input logic             lost_o,
  input logic [CNT_W-1:0] data_cnt_o,
  input logic             higher_w,
  input logic             ev_data,
  input logic             ev_save,
  input logic             ev_restore,
  input logic [CNT_W-1:0] saved_w
);
  AST_ARB_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 4'd1) |-> ($past(phase_o) == 4'd0 && $past(bus_free_i))); // R2

  AST_LOSS_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 4'd1 && higher_w) |=> (phase_o == 4'd0 && lost_o)); // R3

  AST_WIN_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 4'd1 && !higher_w) |=> (phase_o == 4'd2 && data_cnt_o == '0)); // R5

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> (data_cnt_o == CNT_W'($past(data_cnt_o) + 1'b1))); // R5

  AST_SAVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save |=> (saved_w == $past(data_cnt_o))); // R6

  AST_RESTORE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore |=> (data_cnt_o == $past(saved_w))); // R7

  AST_ERR_AT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (phase_o == 4'd0)); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, lost_o})); // R9
endmodule

bind init_phase_seq init_phase_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_free_i (bus_free_i),
  .phase_o    (phase_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .lost_o     (lost_o),
  .data_cnt_o (data_cnt_o),
  .higher_w   (higher_w),
  .ev_data    (ev_data),
  .ev_save    (ev_save),
  .ev_restore (ev_restore),
  .saved_w    (saved_w)
);

// File: tb/init_phase_seq_tb.sv
`timescale 1ns/1ps
module init_phase_seq_tb;
  localparam int OWN = 5;
  localparam int CLEN = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, bus_free_i = 0, sel_ack_i = 0, resel_i = 0, xfer_i = 0;
  logic [7:0] arb_ids_i = '0;
  logic [2:0] tphase_i = '0, msg_i = '0;
  logic [3:0] phase_o;
  logic       arb_req_o, done_o, err_o, lost_o;
  logic [15:0] data_cnt_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  init_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_free_i(bus_free_i),
    .arb_ids_i(arb_ids_i), .sel_ack_i(sel_ack_i), .resel_i(resel_i),
    .tphase_i(tphase_i), .xfer_i(xfer_i), .msg_i(msg_i), .phase_o(phase_o),
    .arb_req_o(arb_req_o), .data_cnt_o(data_cnt_o), .done_o(done_o),
    .err_o(err_o), .lost_o(lost_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_st, m_cnt, m_saved, m_cmd;
  bit m_pend, m_done, m_err, m_lost;
  int ns;
  bit bad, hi;

  function automatic bit legal_in(int st, int tp);
    bit [7:0] okset;
    case (st)
      3: okset = 8'b0010_0000;
      4: okset = 8'b0000_1000;
      5: okset = 8'b0101_0110;
      6, 8: okset = 8'b0100_0000;
      default: okset = 8'hFF;
    endcase
    return (tp == 0) || okset[tp];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_saved = 0; m_cmd = 0;
      m_pend = 0; m_done = 0; m_err = 0; m_lost = 0;
    end else begin
      ns = m_st; m_done = 0; m_err = 0; m_lost = 0;
      bad = !legal_in(m_st, int'(tphase_i));
      if (!bad) begin
        if (m_st == 0) begin
          if (start_i) m_pend = 1;
          if (m_pend && bus_free_i) ns = 1;
        end else if (m_st == 1) begin
          hi = 0;
          for (int k = OWN + 1; k < 8; k++) if (arb_ids_i[k]) hi = 1;
          if (hi) begin ns = 0; m_lost = 1; end
          else begin ns = 2; m_pend = 0; m_cnt = 0; m_saved = 0; m_cmd = 0; end
        end else if (m_st == 2) begin
          if (sel_ack_i) ns = 3;
        end else if (m_st == 3) begin
          if (xfer_i && tphase_i == 5) ns = 4;
        end else if (m_st == 4) begin
          if (xfer_i && tphase_i == 3) begin
            m_cmd++;
            if (m_cmd == CLEN) ns = 5;
          end
        end else if (m_st == 5 && xfer_i) begin
          if (tphase_i == 1 || tphase_i == 2) m_cnt = (m_cnt + 1) % 65536;
          else if (tphase_i == 4) ns = 6;
          else if (tphase_i == 6) begin
            if (msg_i == 1) m_saved = m_cnt;
            else if (msg_i == 2) m_cnt = m_saved;
            else if (msg_i == 3) ns = 7;
            else bad = 1;
          end
        end else if (m_st == 6 && xfer_i && tphase_i == 6) begin
          if (msg_i == 0) begin ns = 0; m_done = 1; end else bad = 1;
        end else if (m_st == 7) begin
          if (resel_i) ns = 8;
        end else if (m_st == 8 && xfer_i && tphase_i == 6) begin
          if (msg_i == 4) ns = 5; else bad = 1;
        end
      end
      if (bad) begin ns = 0; m_pend = 0; m_err = 1; end
      m_st = ns;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (phase_o !== 4'(m_st) || arb_req_o !== (m_st == 1) ||
          data_cnt_o !== 16'(m_cnt) || done_o !== m_done ||
          err_o !== m_err || lost_o !== m_lost) begin
        failures++;
        $display("FAIL %s model: phase=%0d/%0d cnt=%0d/%0d d/e/l=%b%b%b/%b%b%b (actual/expected)",
                 cur_req, phase_o, m_st, data_cnt_o, m_cnt,
                 done_o, err_o, lost_o, m_done, m_err, m_lost);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic xbyte(input logic [2:0] tp, input logic [2:0] mc);
    tphase_i = tp; msg_i = mc; xfer_i = 1'b1;
    cyc();
    tphase_i = '0; msg_i = '0; xfer_i = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic open_cmd();
    start_i = 1; bus_free_i = 1; cyc();   // -> ARB
    start_i = 0; cyc();                   // -> SEL
    sel_ack_i = 1; cyc(); sel_ack_i = 0;  // -> IDENT
    xbyte(3'd5, 3'd0);                    // -> CMD
    repeat (CLEN) xbyte(3'd3, 3'd0);      // -> INFO
    bus_free_i = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    cur_req = "R1";
    chk("R1", "phase after reset", phase_o, 0);
    chk("R1", "cnt after reset", data_cnt_o, 0);
    chk("R1", "flags after reset", {arb_req_o, done_o, err_o, lost_o}, 0);

    // R2: request held while bus busy
    cur_req = "R2";
    start_i = 1; cyc(); start_i = 0;
    cyc(); cyc();
    chk("R2", "no arb on busy bus", phase_o, 0);
    bus_free_i = 1; cyc();
    chk("R2", "arb on free bus", phase_o, 1);
    chk("R2", "arb_req high", arb_req_o, 1);

    // R3: lose to ID 7, retry, then win over lower IDs
    cur_req = "R3";
    arb_ids_i = 8'hA0; cyc();
    chk("R3", "loss returns free", phase_o, 0);
    chk("R3", "lost pulse", lost_o, 1);
    cyc();
    chk("R3", "retry arb", phase_o, 1);
    arb_ids_i = 8'h2C; cyc();
    chk("R3", "win selects", phase_o, 2);
    arb_ids_i = 8'h00; bus_free_i = 0;

    // R4: identify and command bytes
    cur_req = "R4";
    sel_ack_i = 1; cyc(); sel_ack_i = 0;
    chk("R4", "ident state", phase_o, 3);
    xbyte(3'd5, 3'd0);
    chk("R4", "cmd state", phase_o, 4);
    repeat (CLEN - 1) xbyte(3'd3, 3'd0);
    chk("R4", "still cmd before last byte", phase_o, 4);
    xbyte(3'd3, 3'd0);
    chk("R4", "info after cmd bytes", phase_o, 5);

    // R5: data counting
    cur_req = "R5";
    repeat (3) xbyte(3'd2, 3'd0);
    cyc();
    repeat (2) xbyte(3'd1, 3'd0);
    chk("R5", "count after 5 bytes", data_cnt_o, 5);
    tphase_i = 3'd2; cyc(); tphase_i = 3'd0;
    chk("R5", "no strobe no count", data_cnt_o, 5);

    // R6: save then disconnect
    cur_req = "R6";
    xbyte(3'd6, 3'd1);
    xbyte(3'd2, 3'd0);
    chk("R6", "count after save+1", data_cnt_o, 6);
    xbyte(3'd6, 3'd3);
    chk("R6", "disconnected", phase_o, 7);

    // R10: start ignored while busy; R7 phases ignored in DISC
    cur_req = "R10";
    start_i = 1; bus_free_i = 1; cyc(); start_i = 0; cyc();
    chk("R10", "start ignored in disc", phase_o, 7);
    bus_free_i = 0;
    cur_req = "R7";
    tphase_i = 3'd3; cyc(); tphase_i = 3'd0;
    chk("R7", "phase ignored in disc", phase_o, 7);
    chk("R7", "no err in disc", err_o, 0);

    // R7: reselection and restore
    resel_i = 1; cyc(); resel_i = 0;
    chk("R7", "resel state", phase_o, 8);
    xbyte(3'd6, 3'd4);
    chk("R7", "back to info", phase_o, 5);
    repeat (2) xbyte(3'd2, 3'd0);
    chk("R7", "count before restore", data_cnt_o, 8);
    xbyte(3'd6, 3'd2);
    chk("R7", "restored count", data_cnt_o, 5);
    xbyte(3'd1, 3'd0);

    // R8: status and completion
    cur_req = "R8";
    xbyte(3'd4, 3'd0);
    chk("R8", "status state", phase_o, 6);
    xbyte(3'd6, 3'd0);
    chk("R8", "free after complete", phase_o, 0);
    chk("R8", "done pulse", done_o, 1);
    cyc();
    chk("R8", "done one cycle", done_o, 0);

    // R10: earlier start not remembered
    cur_req = "R10";
    bus_free_i = 1; cyc(); cyc();
    chk("R10", "stays free", phase_o, 0);
    bus_free_i = 0;

    // R9: wrong phase during command bytes
    cur_req = "R9";
    start_i = 1; bus_free_i = 1; cyc(); start_i = 0; cyc();
    chk("R5", "count cleared on win", data_cnt_o, 0);
    sel_ack_i = 1; cyc(); sel_ack_i = 0;
    xbyte(3'd5, 3'd0);
    xbyte(3'd3, 3'd0);
    tphase_i = 3'd2; cyc(); tphase_i = 3'd0;
    chk("R9", "err on data in cmd", err_o, 1);
    chk("R9", "free after err", phase_o, 0);
    cyc();
    chk("R9", "request dropped", phase_o, 0);

    // R9: identify message in INFO
    open_cmd();
    xbyte(3'd6, 3'd4);
    chk("R9", "err on ident in info", err_o, 1);

    // R9: wrong message in STAT
    open_cmd();
    xbyte(3'd4, 3'd0);
    xbyte(3'd6, 3'd1);
    chk("R9", "err on save in stat", err_o, 1);
    chk("R9", "free after stat err", phase_o, 0);

    // R3 edge: start and free bus together, loss, immediate retry with win
    cur_req = "R3";
    start_i = 1; bus_free_i = 1; cyc(); start_i = 0;
    chk("R2", "start with free bus", phase_o, 1);
    arb_ids_i = 8'h40; cyc();
    chk("R3", "lost to id6", lost_o, 1);
    arb_ids_i = 8'h00; cyc();
    chk("R3", "rearb", phase_o, 1);
    cyc();
    chk("R3", "won", phase_o, 2);
    bus_free_i = 0;
    repeat (3) cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule